// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block is the digital half of a 10-bit successive-approximation converter. Software writes a byte-wide control register on a simple register bus to pick an input channel and start a conversion. The block then drives a 4-bit channel code to an external analog multiplexer and a 10-bit trial code to an external DAC. Once per step it samples a single comparator bit, and it settles one code bit per step, starting at the most significant bit.

When the last bit is settled, the block copies the code into a two-byte result register, sets an end-of-conversion flag in the control register and goes idle. Software polls the flag and reads the result. Nothing protects the result: the next conversion replaces it whether or not it has been read. The time spent on each step, which allows for DAC settling, is a parameter.

Top module: `sar_ctrl`

## Requirements
- R1: A conversion settles code bits from bit 9 down to bit 0, one per step. At the end of a step, a comparator value of 1 (input at or above the DAC code) keeps the trial bit and a 0 clears it. The next lower bit is then set as the new trial, so the final code is the largest code not above the input.
- R2: The cycle after a conversion starts, the DAC code is 0x200.
- R3: The control register is at byte address 0xF7. Bits 7:4 hold the channel field, which reads back the last value written. Bit 3 is the end-of-conversion flag and cannot be written. Bits 2:0 read as 0. Writing a 1 to bit 0 requests a start.
- R4: The end-of-conversion flag reads 1 exactly 10×SETTLE clock cycles after the bus write that started the conversion. Each step takes SETTLE cycles.
- R5: Starting a conversion clears the end-of-conversion flag, and the start bit reads 0 from then on.
- R6: The channel output is taken from the channel field when a conversion starts and does not change until that conversion ends. Field values 9 to 15 produce channel 0.
- R7: The result high byte at address 0xF5 holds code bits 9:2. The low byte at 0xF6 holds code bits 1:0 in its bits 7:6, and its other bits read 0.
- R8: A start request written while a conversion is running is ignored. The running conversion keeps its channel, its timing and its result.
- R9: A new conversion overwrites an unread result.
- R10: After reset, the control register, both result bytes, the channel output and the DAC code are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register bus byte address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cmp_in | input | 1 | Comparator: 1 when the analog input is at or above the DAC output |
| chan_sel | output | 4 | Channel code to the analog multiplexer |
| dac_code | output | 10 | Trial code to the DAC |

## Verification
A wrong step counter or bit index shows up first as a change in the end-of-conversion latency, which the bench measures to the cycle on every run. A fault in the keep-or-clear decision shows up as a wrong result code once the conversion ends. The bench drives inputs spread across the whole code range, including both end codes, so any corrupted bit reaches the result bytes within one conversion. A wrong latch of the channel appears on chan_sel within one cycle of the start, and it also changes the result, because the comparator model follows the selected channel. A start request taken while busy moves the flag's timing and is visible at the end of that same conversion.

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int SETTLE = 4,
  parameter logic [7:0] CTRL_ADDR   = 8'hF7,
  parameter logic [7:0] RES_HI_ADDR = 8'hF5,
  parameter logic [7:0] RES_LO_ADDR = 8'hF6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       cmp_in,
  output logic [3:0] chan_sel,
  output logic [9:0] dac_code
);
  localparam int NBITS = 10;
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [3:0] LAST_CH = 4'd8;

  logic [3:0]    sel_field;
  logic          eoc;
  logic          busy;
  logic [3:0]    chan_q;
  logic [9:0]    trial;
  logic [9:0]    result;
  logic [3:0]    idx;
  logic [CW-1:0] cnt;

  wire ctrl_wr  = bus_wr && (bus_addr == CTRL_ADDR);
  wire go       = ctrl_wr && bus_wdata[0] && !busy;
  wire step_end = busy && (cnt == CW'(SETTLE - 1));
  wire last     = (idx == 4'd0);

  wire [9:0] mask = 10'd1 << idx;
  wire [9:0] kept = cmp_in ? trial : (trial & ~mask);
  wire [9:0] next_trial = last ? kept : (kept | (mask >> 1));
  wire [3:0] start_ch = (bus_wdata[7:4] > LAST_CH) ? 4'd0 : bus_wdata[7:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_field <= '0;
      eoc       <= 1'b0;
      busy      <= 1'b0;
      chan_q    <= '0;
      trial     <= '0;
      result    <= '0;
      idx       <= '0;
      cnt       <= '0;
    end else begin
      if (ctrl_wr) sel_field <= bus_wdata[7:4];
      if (go) begin
        busy   <= 1'b1;
        eoc    <= 1'b0;
        trial  <= 10'h200;
        idx    <= 4'(NBITS - 1);
        cnt    <= '0;
        chan_q <= start_ch;
      end else if (busy) begin
        if (step_end) begin
          cnt   <= '0;
          trial <= next_trial;
          if (last) begin
            busy   <= 1'b0;
            eoc    <= 1'b1;
            result <= kept;
          end else begin
            idx <= idx - 4'd1;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign chan_sel = chan_q;
  assign dac_code = trial;

  always_comb begin
    case (bus_addr)
      CTRL_ADDR:   bus_rdata = {sel_field, eoc, 3'b000};
      RES_HI_ADDR: bus_rdata = result[9:2];
      RES_LO_ADDR: bus_rdata = {result[1:0], 6'b0};
      default:     bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       eoc,
  input logic [3:0] chan_sel,
  input logic [9:0] dac_code,
  input logic [9:0] result
);
  p_mid_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> dac_code == 10'h200);

  p_eoc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !eoc);

  p_eoc_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> eoc);

  p_chan_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chan_sel));

  p_chan_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chan_sel <= 4'd8);

  p_one_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $countones(dac_code ^ $past(dac_code)) <= 2);

  p_result_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(busy));
endmodule

bind sar_ctrl sar_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .eoc(eoc),
  .chan_sel(chan_sel), .dac_code(dac_code), .result(result)
);

// File: tb/sim_sar_ctrl.sv
`timescale 1ns/1ps
module sim_sar_ctrl;
  localparam int SETTLE = 4;
  localparam int CONV = 10 * SETTLE;
  localparam logic [7:0] A_CTRL = 8'hF7, A_HI = 8'hF5, A_LO = 8'hF6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic cmp_in;
  logic [3:0] chan_sel;
  logic [9:0] dac_code;
  logic [9:0] vin [16];

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  assign cmp_in = (vin[chan_sel] >= dac_code);

  sar_ctrl #(.SETTLE(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
    .chan_sel(chan_sel), .dac_code(dac_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] eff_ch(input logic [3:0] f);
    return (f > 4'd8) ? 4'd0 : f;
  endfunction

  function automatic logic [7:0] exp_hi(input logic [9:0] c);
    return c[9:2];
  endfunction

  function automatic logic [7:0] exp_lo(input logic [9:0] c);
    return {c[1:0], 6'b0};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic wait_eoc(output int n);
    logic [7:0] d;
    n = 0;
    rd(A_CTRL, d);
    while (!d[3] && n < 1000) begin
      @(negedge clk);
      n++;
      rd(A_CTRL, d);
    end
  endtask

  task automatic convert(input logic [3:0] f, input string req);
    logic [7:0] d;
    logic [9:0] e;
    int n;
    e = vin[eff_ch(f)];
    wr(A_CTRL, {f, 4'b0001});
    check(chan_sel == eff_ch(f), "R6", chan_sel, eff_ch(f));
    wait_eoc(n);
    check(n == CONV, "R4", n, CONV);
    rd(A_HI, d); check(d == exp_hi(e), req, d, exp_hi(e));
    rd(A_LO, d); check(d == exp_lo(e), "R7", d, exp_lo(e));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) vin[i] = 10'(i * 61 + 7);

    repeat (3) @(negedge clk);
    // R10 reset state
    rd(A_CTRL, d); check(d == 8'h00, "R10", d, 0);
    rd(A_HI, d);   check(d == 8'h00, "R10", d, 0);
    rd(A_LO, d);   check(d == 8'h00, "R10", d, 0);
    check(chan_sel == 4'd0 && dac_code == 10'd0, "R10", {chan_sel, dac_code}, 0);
    rst_n = 1'b1;

    // R3 field readback, R3 eoc not writable, bits 2:0 read 0
    wr(A_CTRL, 8'h5E);
    rd(A_CTRL, d); check(d == 8'h50, "R3", d, 8'h50);

    // R2/R5 start state; R1 first decision for an input below half scale
    vin[3] = 10'h155;
    wr(A_CTRL, 8'h31);
    check(dac_code == 10'h200, "R2", dac_code, 10'h200);
    rd(A_CTRL, d); check(d == 8'h30, "R5", d, 8'h30);
    repeat (SETTLE) @(negedge clk);
    check(dac_code == 10'h100, "R1", dac_code, 10'h100);
    wait_eoc(n);
    check(n == CONV - SETTLE, "R4", n, CONV - SETTLE);
    rd(A_HI, d); check(d == 8'h55, "R1", d, 8'h55);
    rd(A_LO, d); check(d == 8'h40, "R7", d, 8'h40);

    // R1 boundary codes
    vin[4] = 10'h3FF; convert(4'd4, "R1");
    vin[5] = 10'h000; convert(4'd5, "R1");
    vin[6] = 10'h200; convert(4'd6, "R1");
    vin[7] = 10'h1FF; convert(4'd7, "R1");

    // R6 out-of-range channel maps to 0
    vin[0] = 10'h2C3; vin[12] = 10'h011;
    convert(4'd12, "R6");

    // R8 start while busy is ignored
    vin[1] = 10'h2AB; vin[2] = 10'h0F0;
    wr(A_CTRL, 8'h11);
    repeat (6) @(negedge clk);
    wr(A_CTRL, 8'h21);
    check(chan_sel == 4'd1, "R8", chan_sel, 1);
    wait_eoc(n);
    check(n == CONV - 8, "R8", n, CONV - 8);
    rd(A_HI, d); check(d == exp_hi(10'h2AB), "R8", d, exp_hi(10'h2AB));
    rd(A_CTRL, d); check(d == 8'h28, "R3", d, 8'h28);

    // R9 unread result is overwritten
    vin[8] = 10'h3A5;
    convert(4'd8, "R9");

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [3:0] f;
      f = 4'($urandom_range(0, 15));
      vin[eff_ch(f)] = 10'($urandom_range(0, 1023));
      convert(f, "R1");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule